// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns a system clock into the nominal bit schedule of a CAN node. A prescaler divides the clock into time quanta. A segment sequencer then walks each bit through a one-quantum synchronization slot, a first timing segment (propagation plus first phase) and a second phase segment. It raises a one-cycle sample strobe where the first timing segment ends, and a one-cycle bit strobe where the second phase segment ends.

A falling bus edge (recessive to dominant) realigns the schedule. On an idle bus the edge restarts the bit (hard synchronization). During a frame the edge stretches or trims the current bit by the measured phase error, limited by the jump width. The timing settings sit in one packed 16-bit word that stores every length minus one. That word can be changed only while the init and configuration-enable controls are both high. While init is high the sequencer does not run.

Top module: `can_bit_timing`

## Requirements
- R1: `cfg_wdata` is stored on a `cfg_wr` clock edge only when `ctl_init` and `ctl_cfg_en` are both 1; any other write leaves `cfg_rdata` unchanged. Bit 15 is always stored as 0, and `cfg_rdata` shows the stored word.
- R2: The word's bits 5:0 hold P, and a time quantum lasts P+1 clock cycles; P=0 gives one clock per quantum.
- R3: Bits 11:8 hold T1−1 and bits 14:12 hold T2−1. With no bus edge, successive `bit_stb` pulses are (1+T1+T2)·(P+1) cycles apart.
- R4: `sample_stb` pulses for one cycle (1+T1)·(P+1) cycles after a `bit_stb`, and it is never high in the same cycle as `bit_stb`.
- R5: `cfg_invalid` is 1 exactly when the stored bits 14:12 equal 0, i.e. the second phase segment is shorter than two quanta.
- R6: While `ctl_init` is 1 neither strobe pulses. If the first cycle with `ctl_init` low is cycle j, the first `sample_stb` comes at j+P+T1·(P+1) and the first `bit_stb` at j+P+(T1+T2)·(P+1).
- R7: Bits 7:6 hold SJW−1. If `rx_fall` arrives with `bus_idle`=0 in quantum c (counting from 0) of the first timing segment, that segment grows by min(c+1, SJW) quanta.
- R8: If `rx_fall` arrives with `bus_idle`=0 in quantum c of the second phase segment, that segment shrinks by min(T2−1−c, SJW) quanta.
- R9: An edge in the synchronization slot has no effect, and only the first resynchronizing edge in a bit has any effect.
- R10: `rx_fall` with `bus_idle`=1 in cycle k restarts the bit: the synchronization slot starts at k+1, and `sample_stb` follows at k+1+P+T1·(P+1).
- R11: During and right after reset both strobes are 0, `cfg_rdata` equals the reset word 0x2301 and `cfg_invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_init | input | 1 | Init mode; holds the sequencer and opens configuration |
| ctl_cfg_en | input | 1 | Configuration enable |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 16 | Timing word to write |
| cfg_rdata | output | 16 | Stored timing word |
| cfg_invalid | output | 1 | Second phase segment below two quanta |
| bus_idle | input | 1 | Bus idle; selects hard synchronization |
| rx_fall | input | 1 | One-cycle recessive-to-dominant edge pulse |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| bit_stb | output | 1 | One-cycle strobe at the end of each bit |

## Verification
A wrong quantum count or a segment length that is off by one moves the next `sample_stb` or `bit_stb` by whole quanta. This shows up within one bit time of the fault. A leftover phase adjustment shows up in the bit that follows. The bench times both strobes from a known `bit_stb` and compares them to the cycle computed for each edge position, so an error in the cap or in the choice of segment moves a strobe within that same bit. A write that gets through the gating is visible at once on `cfg_rdata`.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int BRP_W = 6;
  localparam int SJW_W = 2;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int CFG_W = 1 + TS2_W + TS1_W + SJW_W + BRP_W;
  localparam int CNT_W = TS1_W + 1;

  typedef struct packed {
    logic             pad;
    logic [TS2_W-1:0] tseg2_m1;
    logic [TS1_W-1:0] tseg1_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [BRP_W-1:0] brp_m1;
  } cbt_cfg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } cbt_seg_e;

  function automatic logic [CNT_W-1:0] cbt_min(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [CNT_W-1:0] cbt_len(input logic [CNT_W-1:0] m1);
    return m1 + CNT_W'(1);
  endfunction

  function automatic logic cbt_cfg_ok(input cbt_cfg_t c);
    return c.tseg2_m1 != '0;
  endfunction
endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg
  import cbt_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_WORD = 16'h2301
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_init,
  input  logic             ctl_cfg_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output cbt_cfg_t         cfg_q,
  output logic             cfg_ok
);
  localparam logic [CFG_W-1:0] CFG_MASK = {1'b0, {(CFG_W-1){1'b1}}};

  logic wr_open;
  assign wr_open = ctl_init & ctl_cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                cfg_q <= cbt_cfg_t'(RESET_WORD & CFG_MASK);
    else if (wr_open && cfg_wr) cfg_q <= cbt_cfg_t'(cfg_wdata & CFG_MASK);
  end

  assign cfg_ok = cbt_cfg_ok(cfg_q);

  assert_write_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_init && ctl_cfg_en) |=> $stable(cfg_q));
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp_m1,
  output logic             tq_tick
);
  logic [BRP_W-1:0] pre_cnt;

  assign tq_tick = !hold && (pre_cnt == brp_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (hold || restart)  pre_cnt <= '0;
    else if (tq_tick)          pre_cnt <= '0;
    else                       pre_cnt <= pre_cnt + BRP_W'(1);
  end

  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n || hold)
    pre_cnt <= brp_m1);
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tq_tick,
  input  logic             rx_fall,
  input  logic             bus_idle,
  input  logic [TS1_W-1:0] tseg1_m1,
  input  logic [TS2_W-1:0] tseg2_m1,
  input  logic [SJW_W-1:0] sjw_m1,
  output logic             hard_go,
  output logic             sample_stb,
  output logic             bit_stb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cbt_seg_e         seg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ph1_ext;
  logic [CNT_W-1:0] ph2_short;
  logic             resync_done;

  logic [CNT_W-1:0] t1_len, t2_len, sjw;
  logic [CNT_W-1:0] add_now, sub_now, ext_eff, shr_eff;
  logic             in_ph1, in_ph2, resync_go, t1_last, t2_last;

  assign t1_len = cbt_len(CNT_W'(tseg1_m1));
  assign t2_len = cbt_len(CNT_W'(tseg2_m1));
  assign sjw    = cbt_len(CNT_W'(sjw_m1));

  assign in_ph1 = (seg == SEG_PH1);
  assign in_ph2 = (seg == SEG_PH2);

  assign hard_go   = !hold && rx_fall && bus_idle;
  assign resync_go = !hold && rx_fall && !bus_idle && !resync_done && (in_ph1 || in_ph2);

  assign add_now = cbt_min(cnt + ONE, sjw);
  assign sub_now = cbt_min(t2_len - ONE - cnt, sjw);
  assign ext_eff = (resync_go && in_ph1) ? add_now : ph1_ext;
  assign shr_eff = (resync_go && in_ph2) ? sub_now : ph2_short;

  assign t1_last = in_ph1 && (cnt == t1_len + ext_eff - ONE);
  assign t2_last = in_ph2 && (cnt == t2_len - shr_eff - ONE);

  assign sample_stb = tq_tick && t1_last && !hard_go;
  assign bit_stb    = tq_tick && t2_last && !hard_go;

  always_ff @(posedge clk) begin
    if (!rst_n || hold || hard_go) begin
      seg         <= SEG_SYNC;
      cnt         <= '0;
      ph1_ext     <= '0;
      ph2_short   <= '0;
      resync_done <= 1'b0;
    end else begin
      if (resync_go) begin
        resync_done <= 1'b1;
        if (in_ph1) ph1_ext   <= add_now;
        if (in_ph2) ph2_short <= sub_now;
      end
      if (tq_tick) begin
        case (seg)
          SEG_SYNC: begin
            seg <= SEG_PH1;
            cnt <= '0;
          end
          SEG_PH1: begin
            if (t1_last) begin
              seg <= SEG_PH2;
              cnt <= '0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          SEG_PH2: begin
            if (t2_last) begin
              seg         <= SEG_SYNC;
              cnt         <= '0;
              ph1_ext     <= '0;
              ph2_short   <= '0;
              resync_done <= 1'b0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          default: begin
            seg <= SEG_SYNC;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));
  assert_init_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!sample_stb && !bit_stb));
  assert_ext_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_ext <= sjw);
  assert_short_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_short <= sjw);
  assert_one_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_done && !bit_stb && !hold && !hard_go) |=>
      ($stable(ph1_ext) && $stable(ph2_short)));
  assert_hard_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hard_go |=> (seg == SEG_SYNC && cnt == '0 && !resync_done));
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter logic [15:0] RESET_WORD = 16'h2301
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_init,
  input  logic        ctl_cfg_en,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic        cfg_invalid,
  input  logic        bus_idle,
  input  logic        rx_fall,
  output logic        sample_stb,
  output logic        bit_stb
);
  cbt_cfg_t cfg_q;
  logic     cfg_ok;
  logic     tq_tick;
  logic     hard_go;

  cbt_cfg_reg #(.RESET_WORD(RESET_WORD)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_init  (ctl_init),
    .ctl_cfg_en(ctl_cfg_en),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_ok    (cfg_ok)
  );

  cbt_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (ctl_init),
    .restart(hard_go),
    .brp_m1 (cfg_q.brp_m1),
    .tq_tick(tq_tick)
  );

  cbt_seg_fsm u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (ctl_init),
    .tq_tick   (tq_tick),
    .rx_fall   (rx_fall),
    .bus_idle  (bus_idle),
    .tseg1_m1  (cfg_q.tseg1_m1),
    .tseg2_m1  (cfg_q.tseg2_m1),
    .sjw_m1    (cfg_q.sjw_m1),
    .hard_go   (hard_go),
    .sample_stb(sample_stb),
    .bit_stb   (bit_stb)
  );

  assign cfg_rdata   = cfg_q;
  assign cfg_invalid = !cfg_ok;
endmodule

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_init = 1'b1;
  logic        ctl_cfg_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cfg_invalid;
  logic        bus_idle = 1'b0;
  logic        rx_fall = 1'b0;
  logic        sample_stb;
  logic        bit_stb;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rst_n(rst_n), .ctl_init(ctl_init), .ctl_cfg_en(ctl_cfg_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_invalid(cfg_invalid), .bus_idle(bus_idle), .rx_fall(rx_fall),
    .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  e;
    logic [7:0]  e2;
    logic        idle;
    logic [7:0]  s;
    logic [7:0]  b;
  } vec_t;

  // word, edge cycle, second edge cycle, idle, sample offset, bit offset (from a bit_stb)
  localparam vec_t VECS [12] = '{
    '{16'h5EC0, 8'd0,  8'd0, 1'b0, 8'd16, 8'd22},
    '{16'h5EC2, 8'd0,  8'd0, 1'b0, 8'd48, 8'd66},
    '{16'h1200, 8'd0,  8'd0, 1'b0, 8'd4,  8'd6},
    '{16'h5EC0, 8'd3,  8'd0, 1'b0, 8'd18, 8'd24},
    '{16'h5EC0, 8'd8,  8'd0, 1'b0, 8'd20, 8'd26},
    '{16'h5EC0, 8'd18, 8'd0, 1'b0, 8'd16, 8'd18},
    '{16'h5EC0, 8'd20, 8'd0, 1'b0, 8'd16, 8'd20},
    '{16'h5E00, 8'd8,  8'd0, 1'b0, 8'd17, 8'd23},
    '{16'h5EC0, 8'd1,  8'd0, 1'b0, 8'd16, 8'd22},
    '{16'h5EC0, 8'd5,  8'd0, 1'b1, 8'd21, 8'd27},
    '{16'h5EC0, 8'd3,  8'd6, 1'b0, 8'd18, 8'd24},
    '{16'h5EC0, 8'd17, 8'd0, 1'b0, 8'd16, 8'd18}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input vec_t v);
    int t1;
    t1 = int'(v.word[11:8]) + 1;
    if (v.idle)                return "R10";
    if (v.e2 != 0)             return "R9";
    if (v.e == 0)              return (v.word[5:0] != 0) ? "R2" : "R3";
    if (v.e == 1)              return "R9";
    if (int'(v.e) <= 1 + t1)   return "R7";
    return "R8";
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic i, input logic c, input logic [15:0] w);
    @(negedge clk);
    ctl_init = i; ctl_cfg_en = c; cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic wait_bit(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 400; n++) begin
      tick();
      if (bit_stb) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int fs, fb, quiet, t;
    string rq;

    // R11: reset state
    repeat (3) tick();
    check("R11", "sample_stb in reset", 32'(sample_stb), 0);
    check("R11", "bit_stb in reset", 32'(bit_stb), 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R11", "cfg_rdata after reset", 32'(cfg_rdata), 32'h2301);
    check("R11", "cfg_invalid after reset", 32'(cfg_invalid), 0);

    // R1: write gating
    write_cfg(1'b1, 1'b0, 16'h1234);
    check("R1", "write with cfg_en low", 32'(cfg_rdata), 32'h2301);
    write_cfg(1'b0, 1'b1, 16'h1234);
    check("R1", "write with init low", 32'(cfg_rdata), 32'h2301);
    write_cfg(1'b1, 1'b1, 16'hDEC0);
    check("R1", "write accepted, bit15 cleared", 32'(cfg_rdata), 32'h5EC0);

    // R5: invalid flag
    write_cfg(1'b1, 1'b1, 16'h0E00);
    check("R5", "tseg2 field 0 flags invalid", 32'(cfg_invalid), 1);
    write_cfg(1'b1, 1'b1, 16'h1E00);
    check("R5", "tseg2 field 1 is valid", 32'(cfg_invalid), 0);

    // R6: init holds, then release timing
    write_cfg(1'b1, 1'b1, 16'h5EC0);
    quiet = 0;
    for (int n = 0; n < 60; n++) begin
      tick();
      if (sample_stb || bit_stb) quiet++;
    end
    check("R6", "strobes while init high", 32'(quiet), 0);
    @(negedge clk);
    ctl_init = 1'b0; ctl_cfg_en = 1'b0;
    #1;
    fs = -1; fb = -1;
    for (int n = 0; n < 60; n++) begin
      if (n > 0) tick();
      if (sample_stb && fs < 0) fs = n;
      if (bit_stb && fb < 0) begin fb = n; break; end
    end
    check("R6", "first sample after init release", 32'(fs), 15);
    check("R6", "first bit after init release", 32'(fb), 21);

    // table of timing vectors
    foreach (VECS[i]) begin
      rq = req_of(VECS[i]);
      write_cfg(1'b1, 1'b1, VECS[i].word);
      @(negedge clk);
      ctl_init = 1'b0; ctl_cfg_en = 1'b0;
      wait_bit(ok);
      check(rq, "bit strobe seen before measurement", 32'(ok), 1);
      fs = 0; fb = 0;
      for (int n = 1; n < 150; n++) begin
        @(negedge clk);
        rx_fall  = (n == int'(VECS[i].e) && VECS[i].e != 0) ||
                   (n == int'(VECS[i].e2) && VECS[i].e2 != 0);
        bus_idle = VECS[i].idle && (n == int'(VECS[i].e));
        #1;
        if (sample_stb && fs == 0) fs = n;
        if (bit_stb && fb == 0) begin fb = n; break; end
      end
      @(negedge clk);
      rx_fall = 1'b0; bus_idle = 1'b0;
      t = i;
      check((VECS[i].e == 0) ? "R4" : rq, $sformatf("vector %0d sample offset", t),
            32'(fs), 32'(VECS[i].s));
      check(rq, $sformatf("vector %0d bit offset", t), 32'(fb), 32'(VECS[i].b));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule